// File: doc/BRIEF.md
# Asynchronous SRAM write sequencer

This block turns single write requests into chip-select-terminated write cycles on an external 16-bit static RAM with two byte lanes. A request carries an address, a 16-bit data word and two lane-enable bits. The sequencer drives the address first, together with the active-low primary select, the active-high secondary select and the active-low lane strobes. It then lowers write enable. Only after the memory's own outputs have had time to go to high impedance does it enable its data drivers. The write ends when the primary select is raised, while write enable, the lane strobes and the data are all still held.

Every interval is a whole number of system clocks. Each count is taken from a nanosecond limit of the chosen speed grade and the clock period, by ceiling division with a floor of one cycle. A ready/valid pair admits one request at a time, and a one-cycle completion pulse marks the end of each request.

Top module: `asram_write_seq`

## Requirements
- R1: While reset is high, and after it, the block sits idle: req_ready=1, wr_done=0, mem_sel_n=1, mem_sel2=0, mem_we_n=1, mem_lo_n=1, mem_hi_n=1, mem_dout_oe=0.
- R2: Whenever mem_we_n is low, mem_sel2 is high and at least one of mem_lo_n and mem_hi_n is low.
- R3: The lower strobe mem_lo_n (data bits 7:0) is low during a write exactly when req_be bit 0 was set. The upper strobe mem_hi_n (bits 15:8) is low exactly when req_be bit 1 was set. mem_addr equals the request address, and neither the strobes nor the address change, from the fall of mem_sel_n until it rises.
- R4: The write is ended by the rise of mem_sel_n. In that cycle mem_we_n is still low, mem_sel2 is high, the strobes are unchanged and the data is still driven. One cycle later mem_we_n, both strobes and mem_sel2 are released and mem_dout_oe is off.
- R5: mem_we_n falls one clock after mem_sel_n falls. It then stays low with mem_dout_oe off for H = ceil(20 ns / period) cycles.
- R6: mem_dout_oe is then on with mem_dout equal to the request data for D cycles before mem_sel_n rises. D is the largest of ceil(tSD/period), Npwe-H, P-1-H and 1, where P is the largest of the select, address and strobe setup counts.
- R7: The grade picks the limits. Fast grade: cycle 45, select/address/strobe setup 35, write pulse 35, data setup 20 ns. Slow grade: cycle 55, setups 45, write pulse 40, data setup 25 ns. The output high-impedance wait is 20 ns in both grades. mem_sel_n stays low for 1+H+D cycles.
- R8: After the release cycle the block pads with R = max(1, Nwc-(H+D+2)) idle cycles. wr_done then pulses for one cycle, T = H+D+2+R clocks after mem_sel_n fell. Successive falls of mem_sel_n are at least Nwc clocks apart.
- R9: A request with req_be=00 is accepted, raises wr_done in the next cycle and leaves every memory pin idle.
- R10: req_ready is low from the accepting edge of a write until the cycle in which wr_done rises, when it is high again. A request waiting in that cycle is accepted, and mem_sel_n falls one clock later. Request inputs changed during a write do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Write address |
| req_data | input | 2*LANE_W | Write data |
| req_be | input | 2 | Lane enables, bit 0 lower lane, bit 1 upper lane |
| wr_done | output | 1 | One-cycle completion pulse |
| mem_sel_n | output | 1 | Primary chip select, active low, terminates the write |
| mem_sel2 | output | 1 | Secondary chip select, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lo_n | output | 1 | Lower lane strobe, active low |
| mem_hi_n | output | 1 | Upper lane strobe, active low |
| mem_addr | output | ADDR_W | Address bus |
| mem_dout | output | 2*LANE_W | Data bus value |
| mem_dout_oe | output | 1 | Data driver enable |

## Verification
The two events that can share a cycle are the completion pulse of one request and the acceptance of the next. The driver keeps req_valid high with the next item already on the inputs while a write runs. The monitor checks that req_ready stays low throughout the write, that the waiting request is taken in the wr_done cycle, that mem_sel_n falls exactly one clock later, and that the new input values never leak into the write still in flight. Zero-lane requests placed directly before and after full writes make done and acceptance coincide on consecutive cycles as well.

// File: rtl/asram_wr_pkg.sv
`timescale 1ns/100ps
package asram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_STROBE  = 3'd2,
    ST_DRIVE   = 3'd3,
    ST_END     = 3'd4,
    ST_RECOVER = 3'd5
  } wr_state_e;

  typedef enum logic [2:0] {
    LIM_CYCLE,
    LIM_SEL,
    LIM_ADDR,
    LIM_LANE,
    LIM_WE_PULSE,
    LIM_DATA_SETUP,
    LIM_OUT_HIZ
  } limit_e;

  // Nanosecond limit for a grade (slow=1 is the 55 ns grade)
  function automatic int limit_ns(input bit slow, input limit_e k);
    int v;
    case (k)
      LIM_CYCLE:      v = slow ? 55 : 45;
      LIM_SEL:        v = slow ? 45 : 35;
      LIM_ADDR:       v = slow ? 45 : 35;
      LIM_LANE:       v = slow ? 45 : 35;
      LIM_WE_PULSE:   v = slow ? 40 : 35;
      LIM_DATA_SETUP: v = slow ? 25 : 20;
      default:        v = 20;
    endcase
    return v;
  endfunction

  function automatic int to_cycles(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int limit_cyc(input bit slow, input limit_e k, input int period);
    return to_cycles(limit_ns(slow, k), period);
  endfunction

endpackage

// File: rtl/asram_wr_interval.sv
`timescale 1ns/100ps
module asram_wr_interval #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= value_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/asram_wr_fsm.sv
`timescale 1ns/100ps
module asram_wr_fsm
  import asram_wr_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int STROBE_LEN  = 4,
  parameter int DRIVE_LEN   = 4,
  parameter int RECOVER_LEN = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic      skip_i,
  output wr_state_e next_o,
  output logic      ready_o,
  output logic      done_o
);

  localparam logic [CNT_W-1:0] STROBE_LD  = CNT_W'(STROBE_LEN - 1);
  localparam logic [CNT_W-1:0] DRIVE_LD   = CNT_W'(DRIVE_LEN - 1);
  localparam logic [CNT_W-1:0] RECOVER_LD = CNT_W'(RECOVER_LEN - 1);

  wr_state_e        state_q;
  wr_state_e        next_s;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;

  asram_wr_interval #(.W(CNT_W)) u_interval (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .value_i  (load_val),
    .expired_o(expired)
  );

  always_comb begin
    next_s   = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          next_s = ST_SETUP;
          load   = 1'b1;
        end
      end
      ST_SETUP: begin
        if (expired) begin
          next_s   = ST_STROBE;
          load     = 1'b1;
          load_val = STROBE_LD;
        end
      end
      ST_STROBE: begin
        if (expired) begin
          next_s   = ST_DRIVE;
          load     = 1'b1;
          load_val = DRIVE_LD;
        end
      end
      ST_DRIVE: begin
        if (expired) begin
          next_s = ST_END;
          load   = 1'b1;
        end
      end
      ST_END: begin
        if (expired) begin
          next_s   = ST_RECOVER;
          load     = 1'b1;
          load_val = RECOVER_LD;
        end
      end
      ST_RECOVER: begin
        if (expired) next_s = ST_IDLE;
      end
      default: next_s = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ready_o <= 1'b1;
      done_o  <= 1'b0;
    end else begin
      state_q <= next_s;
      ready_o <= (next_s == ST_IDLE);
      done_o  <= skip_i || ((state_q == ST_RECOVER) && expired);
    end
  end

  assign next_o = next_s;

  // R8: leaving the pad interval yields done with ready back high
  p_done_after_pad_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RECOVER && expired) |=> (done_o && ready_o && state_q == ST_IDLE));

  // R5: the strobe-only interval is never entered from anything but setup
  p_strobe_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STROBE && $past(state_q) != ST_STROBE) |-> $past(state_q) == ST_SETUP);

endmodule

// File: rtl/asram_wr_pins.sv
`timescale 1ns/100ps
module asram_wr_pins
  import asram_wr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [1:0]        req_be_i,
  input  wr_state_e         next_i,
  output logic              mem_sel_n,
  output logic              mem_sel2,
  output logic              mem_we_n,
  output logic              mem_lo_n,
  output logic              mem_hi_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_oe
);

  logic [1:0] be_q;
  logic [1:0] lane_be;
  logic       sel_on, sel2_on, we_on, lane_on, oe_on;

  assign lane_be = start_i ? req_be_i : be_q;

  always_comb begin
    sel_on  = next_i inside {ST_SETUP, ST_STROBE, ST_DRIVE};
    sel2_on = next_i inside {ST_SETUP, ST_STROBE, ST_DRIVE, ST_END};
    lane_on = sel2_on;
    we_on   = next_i inside {ST_STROBE, ST_DRIVE, ST_END};
    oe_on   = next_i inside {ST_DRIVE, ST_END};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      be_q        <= '0;
      mem_addr    <= '0;
      mem_dout    <= '0;
      mem_sel_n   <= 1'b1;
      mem_sel2    <= 1'b0;
      mem_we_n    <= 1'b1;
      mem_lo_n    <= 1'b1;
      mem_hi_n    <= 1'b1;
      mem_dout_oe <= 1'b0;
    end else begin
      if (start_i) begin
        be_q     <= req_be_i;
        mem_addr <= req_addr_i;
        mem_dout <= req_data_i;
      end
      mem_sel_n   <= !sel_on;
      mem_sel2    <= sel2_on;
      mem_we_n    <= !we_on;
      mem_lo_n    <= !(lane_on && lane_be[0]);
      mem_hi_n    <= !(lane_on && lane_be[1]);
      mem_dout_oe <= oe_on;
    end
  end

  // R2: write enable low only inside a qualified window
  p_we_window_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_sel2 && !(mem_lo_n && mem_hi_n)));

  // R4: primary select rise is the terminating edge, all else held
  p_term_edge_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_sel_n) |-> (!mem_we_n && mem_dout_oe && mem_sel2 && $stable(mem_addr)));

  // R5: data drivers only turn on after write enable is already low
  p_we_before_data_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dout_oe) |-> $past(!mem_we_n));

endmodule

// File: rtl/asram_write_seq.sv
`timescale 1ns/100ps
module asram_write_seq
  import asram_wr_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int LANE_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter bit SLOW_GRADE    = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2*LANE_W-1:0]   req_data,
  input  logic [1:0]            req_be,
  output logic                  wr_done,
  output logic                  mem_sel_n,
  output logic                  mem_sel2,
  output logic                  mem_we_n,
  output logic                  mem_lo_n,
  output logic                  mem_hi_n,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [2*LANE_W-1:0]   mem_dout,
  output logic                  mem_dout_oe
);

  localparam int DATA_W = 2 * LANE_W;
  localparam int N_WC   = limit_cyc(SLOW_GRADE, LIM_CYCLE, CLK_PERIOD_NS);
  localparam int N_SEL  = limit_cyc(SLOW_GRADE, LIM_SEL, CLK_PERIOD_NS);
  localparam int N_ADR  = limit_cyc(SLOW_GRADE, LIM_ADDR, CLK_PERIOD_NS);
  localparam int N_LANE = limit_cyc(SLOW_GRADE, LIM_LANE, CLK_PERIOD_NS);
  localparam int N_PWE  = limit_cyc(SLOW_GRADE, LIM_WE_PULSE, CLK_PERIOD_NS);
  localparam int N_SD   = limit_cyc(SLOW_GRADE, LIM_DATA_SETUP, CLK_PERIOD_NS);
  localparam int N_HZ   = limit_cyc(SLOW_GRADE, LIM_OUT_HIZ, CLK_PERIOD_NS);
  localparam int N_PRE  = imax(N_SEL, imax(N_ADR, N_LANE));
  localparam int N_DRV  = imax(imax(N_SD, N_PWE - N_HZ), imax(N_PRE - 1 - N_HZ, 1));
  localparam int N_REC  = imax(1, N_WC - (N_HZ + N_DRV + 2));
  localparam int N_MAX  = imax(N_HZ, imax(N_DRV, N_REC));
  localparam int CNT_W  = $clog2(N_MAX + 1);

  logic      accept, any_lane, start, skip;
  wr_state_e next_st;

  assign accept   = req_valid && req_ready;
  assign any_lane = |req_be;
  assign start    = accept && any_lane;
  assign skip     = accept && !any_lane;

  asram_wr_fsm #(
    .CNT_W      (CNT_W),
    .STROBE_LEN (N_HZ),
    .DRIVE_LEN  (N_DRV),
    .RECOVER_LEN(N_REC)
  ) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .start_i(start),
    .skip_i (skip),
    .next_o (next_st),
    .ready_o(req_ready),
    .done_o (wr_done)
  );

  asram_wr_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .req_addr_i (req_addr),
    .req_data_i (req_data),
    .req_be_i   (req_be),
    .next_i     (next_st),
    .mem_sel_n  (mem_sel_n),
    .mem_sel2   (mem_sel2),
    .mem_we_n   (mem_we_n),
    .mem_lo_n   (mem_lo_n),
    .mem_hi_n   (mem_hi_n),
    .mem_addr   (mem_addr),
    .mem_dout   (mem_dout),
    .mem_dout_oe(mem_dout_oe)
  );

  // R10: an accepted write drops ready and opens the select next cycle
  p_accept_busy_r10: assert property (@(posedge clk) disable iff (rst)
    start |=> (!mem_sel_n && !req_ready));

  // R9: a request with no lanes completes at once with an idle bus
  p_zero_lanes_r9: assert property (@(posedge clk) disable iff (rst)
    skip |=> (wr_done && mem_sel_n && mem_we_n && req_ready));

endmodule

// File: tb/test_asram_write_seq.sv
`timescale 1ns/100ps
module test_asram_write_seq;

  localparam int TCK = 5;

  typedef struct {
    logic [15:0] a;
    logic [15:0] d;
    logic [1:0]  b;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // fast-grade instance
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [1:0]  req_be = '0;
  logic        wr_done, mem_sel_n, mem_sel2, mem_we_n, mem_lo_n, mem_hi_n, mem_dout_oe;
  logic [15:0] mem_addr, mem_dout;

  asram_write_seq #(.ADDR_W(16), .LANE_W(8), .CLK_PERIOD_NS(TCK), .SLOW_GRADE(1'b0)) i_asram_write_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be), .wr_done(wr_done),
    .mem_sel_n(mem_sel_n), .mem_sel2(mem_sel2), .mem_we_n(mem_we_n),
    .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_oe(mem_dout_oe));

  // slow-grade instance
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_addr = '0;
  logic [15:0] s_data = '0;
  logic [1:0]  s_be = '0;
  logic        s_done, s_sel_n, s_sel2, s_we_n, s_lo_n, s_hi_n, s_oe;
  logic [15:0] s_maddr, s_dout;

  asram_write_seq #(.ADDR_W(16), .LANE_W(8), .CLK_PERIOD_NS(TCK), .SLOW_GRADE(1'b1)) i_asram_write_seq_slow (
    .clk(clk), .rst(rst), .req_valid(s_valid), .req_ready(s_ready),
    .req_addr(s_addr), .req_data(s_data), .req_be(s_be), .wr_done(s_done),
    .mem_sel_n(s_sel_n), .mem_sel2(s_sel2), .mem_we_n(s_we_n),
    .mem_lo_n(s_lo_n), .mem_hi_n(s_hi_n), .mem_addr(s_maddr),
    .mem_dout(s_dout), .mem_dout_oe(s_oe));

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + TCK - 1) / TCK;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // schedule from the requirement text (R5..R8)
  int hf, df, tf, csf, wcf;
  int hs, ds, ts, css;
  initial begin
    hf  = cdiv(20);
    df  = mx(mx(cdiv(20), cdiv(35) - hf), mx(cdiv(35) - 1 - hf, 1));
    wcf = cdiv(45);
    tf  = hf + df + 2 + mx(1, wcf - (hf + df + 2));
    csf = 1 + hf + df;
    hs  = cdiv(20);
    ds  = mx(mx(cdiv(25), cdiv(40) - hs), mx(cdiv(45) - 1 - hs, 1));
    ts  = hs + ds + 2 + mx(1, cdiv(55) - (hs + ds + 2));
    css = 1 + hs + ds;
  end

  item_t exp_q[$];

  // ---------------- monitor / scoreboard ----------------
  bit          mon_on = 0;
  int          sidx = 0, fall_idx = 0, last_fall_idx = 0, end_idx = 0;
  int          n_cs, n_dark, n_drv;
  bit          in_wr = 0, saw_bus = 0, prev_sel_n = 1;
  bit          addr_bad, data_bad, rdy_bad, win_bad = 0, term_ok, rel_ok, drv_seen, fall_we;
  logic [15:0] cap_addr, drv_first;
  logic        cap_lo, cap_hi;

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      item_t e;
      sidx++;
      if (!mem_we_n && !(mem_sel2 && !(mem_lo_n && mem_hi_n))) win_bad = 1;
      if (prev_sel_n && !mem_sel_n) begin
        in_wr = 1; saw_bus = 1; fall_idx = sidx;
        cap_addr = mem_addr; cap_lo = mem_lo_n; cap_hi = mem_hi_n;
        n_cs = 0; n_dark = 0; n_drv = 0; end_idx = 0;
        addr_bad = 0; data_bad = 0; rdy_bad = 0; term_ok = 0; rel_ok = 0; drv_seen = 0;
        fall_we = mem_we_n;
        if (last_fall_idx > 0)
          chk(sidx - last_fall_idx >= wcf, "R8 select spacing", sidx - last_fall_idx, wcf);
        last_fall_idx = sidx;
      end
      if (in_wr && !mem_sel_n) begin
        n_cs++;
        if (!mem_we_n && !mem_dout_oe) n_dark++;
        if (mem_dout_oe) begin
          if (!drv_seen) begin drv_first = mem_dout; drv_seen = 1; end
          else if (mem_dout != drv_first) data_bad = 1;
          n_drv++;
        end
        if (mem_addr != cap_addr || mem_lo_n != cap_lo || mem_hi_n != cap_hi) addr_bad = 1;
        if (req_ready) rdy_bad = 1;
      end
      if (in_wr && !prev_sel_n && mem_sel_n) begin
        end_idx = sidx;
        term_ok = !mem_we_n && mem_dout_oe && mem_sel2 && mem_lo_n == cap_lo &&
                  mem_hi_n == cap_hi && mem_dout == drv_first && mem_addr == cap_addr;
      end
      if (in_wr && end_idx > 0 && sidx == end_idx + 1)
        rel_ok = mem_sel_n && mem_we_n && mem_lo_n && mem_hi_n && !mem_dout_oe && !mem_sel2;
      if (wr_done) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8 done without request", 1, 0);
        end else begin
          e = exp_q.pop_front();
          if (e.b == 2'b00) begin
            chk(!saw_bus, "R9 zero-lane bus quiet", saw_bus, 0);
            chk(mem_sel_n && mem_we_n && mem_lo_n && mem_hi_n && !mem_dout_oe && req_ready,
                "R9 zero-lane idle pins", 0, 1);
          end else begin
            chk(cap_addr == e.a, "R3 address", cap_addr, e.a);
            chk(cap_lo == !e.b[0] && cap_hi == !e.b[1], "R3 lane strobes", {cap_hi, cap_lo}, ~e.b);
            chk(!addr_bad, "R3 address/strobes stable", addr_bad, 0);
            chk(drv_first == e.d && !data_bad, "R6 data", drv_first, e.d);
            chk(fall_we == 1'b1, "R5 write enable after select", fall_we, 1);
            chk(n_dark == hf, "R5 high-z wait", n_dark, hf);
            chk(n_drv == df, "R6 data setup", n_drv, df);
            chk(n_cs == csf, "R7 select low length", n_cs, csf);
            chk(sidx - fall_idx == tf, "R8 select-to-done", sidx - fall_idx, tf);
            chk(term_ok, "R4 terminating edge", term_ok, 1);
            chk(rel_ok, "R4 release cycle", rel_ok, 1);
            chk(!win_bad, "R2 write window", win_bad, 0);
            chk(!rdy_bad && req_ready, "R10 ready busy/return", rdy_bad, 0);
          end
        end
        saw_bus = 0; in_wr = 0; end_idx = 0; win_bad = 0;
      end
      prev_sel_n = mem_sel_n;
    end
  end

  // ---------------- driver ----------------
  task automatic send(input logic [15:0] a, input logic [15:0] d, input logic [1:0] b);
    item_t it;
    req_valid = 1'b1; req_addr = a; req_data = d; req_be = b;
    while (!req_ready) @(negedge clk);
    it.a = a; it.d = d; it.b = b;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic drain();
    req_valid = 1'b0;
    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all requests completed", exp_q.size(), 0);
  endtask

  task automatic slow_run();
    int cs_cnt, t;
    bit lanes_ok, data_ok;
    cs_cnt = 0; t = 0; lanes_ok = 1; data_ok = 0;
    s_valid = 1'b1; s_addr = 16'h1234; s_data = 16'hBEEF; s_be = 2'b10;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    for (int k = 1; k < 100; k++) begin
      if (!s_sel_n) begin
        cs_cnt++;
        if (!(s_hi_n == 1'b0 && s_lo_n == 1'b1 && s_maddr == 16'h1234)) lanes_ok = 0;
        if (s_oe && s_dout == 16'hBEEF) data_ok = 1;
      end
      if (s_done) begin t = k; break; end
      @(negedge clk);
    end
    chk(cs_cnt == css, "R7 slow grade select length", cs_cnt, css);
    chk(t - 1 == ts, "R7 slow grade select-to-done", t - 1, ts);
    chk(lanes_ok && data_ok, "R3 slow grade upper lane only", {lanes_ok, data_ok}, 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(req_ready && !wr_done && mem_sel_n && !mem_sel2 && mem_we_n && mem_lo_n && mem_hi_n && !mem_dout_oe,
        "R1 reset state", 0, 1);
    chk(s_ready && !s_done && s_sel_n && !s_sel2 && s_we_n && !s_oe, "R1 reset state slow", 0, 1);
    rst = 1'b0;
    mon_on = 1;
    @(negedge clk);
    chk(req_ready && mem_sel_n && mem_we_n && !mem_dout_oe, "R1 idle after reset", 0, 1);
    // back-to-back: done and next accept coincide (R10)
    send(16'h0000, 16'hA5C3, 2'b11);
    send(16'hFFFF, 16'h1234, 2'b01);
    send(16'h8001, 16'hFF00, 2'b10);
    send(16'h0001, 16'h0000, 2'b00);
    send(16'h0002, 16'h0000, 2'b00);
    send(16'h55AA, 16'hFFFF, 2'b11);
    send(16'h0007, 16'h0F0F, 2'b00);
    send(16'h3C3C, 16'h8421, 2'b01);
    drain();
    repeat (5) @(negedge clk);
    send(16'h0101, 16'hCAFE, 2'b10);
    drain();
    repeat (3) @(negedge clk);
    slow_run();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule